// File: doc/BRIEF.md
# Oversampled Sampling-Phase Selector

This block takes one word per unit interval (UI) of a serial stream. Each word holds 32 samples of that UI, spaced 1/32 UI apart, with bit 0 the earliest sample. The block returns one retimed bit per UI. The bit is taken from the sample picked by a 5-bit adjust code. The code is two's-complement and counts from the eye center, and it wraps around the UI. Code zero is always the center sample. Positive codes move the decision point later in the eye, negative codes move it earlier, and the most negative code lands half a UI away from the center. The selected position moves monotonically with the code.

The code can be held fixed from a pin. It can also come from a built-in training sweep, which is meant for links whose best decision point is not the center, for example where noise gathers on the leading edge of the eye. The sweep tries every code in turn over a programmable number of bits. It scores each code against a self-synchronizing PRBS7 check and keeps the code with the fewest errors. Words come in and bits go out over valid/ready streams. The output holds one bit. A new word is accepted only when that slot is empty or is being emptied in the same cycle, so back-pressure on the output passes straight back to the input. The adjust and training controls are plain level or pulse pins.

Top module: `phsel_top`

## Requirements
- R1: During and right after reset, m_valid and train_done are 0, s_ready is 1, and sel_code equals adj_code.
- R2: The sample used is bit ((CENTER_IDX + code) mod 32) of s_samples, with CENTER_IDX = 16 by default. Code 5'b00000 picks bit 16, 5'b00001 picks bit 17, 5'b01111 picks bit 31, 5'b10000 picks bit 0, 5'b10001 picks bit 1, and 5'b11111 picks bit 15.
- R3: A word is accepted at a rising edge where s_valid and s_ready are both 1. It is decoded with the sel_code in effect at that edge, so a code change takes effect on a whole-word boundary. Its bit appears on m_bit, with m_valid = 1, after that edge.
- R4: s_ready is 1 exactly when m_valid is 0 or m_ready is 1. While m_valid = 1 and m_ready = 0, m_valid and m_bit hold their values.
- R5: A train_start pulse begins a sweep over codes 0, 1, ..., 31 in ascending unsigned order. During the sweep, sel_code shows the code under test, and the code advances after 7 + train_bits accepted words.
- R6: For each code, the first 7 accepted words only seed the history. Each later word counts one error when its bit differs from the XOR of the bits 6 and 7 words earlier (polynomial x^7 + x^6 + 1). A train_bits value of 0 is treated as 1.
- R7: After code 31 is scored, train_done goes to 1 and the code with the fewest errors is kept. On a tie, the earliest code in the sweep wins. train_done stays at 1 until the next train_start.
- R8: When not sweeping, sel_code equals the kept code if train_done = 1 and use_train = 1. Otherwise it equals adj_code. The data path always uses sel_code.
- R9: A train_start pulse during a sweep restarts the sweep at code 0 and clears train_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Block can accept a word |
| s_samples | input | 32 | Oversampled UI, bit 0 earliest |
| m_valid | output | 1 | Retimed bit valid |
| m_ready | input | 1 | Downstream accepts the bit |
| m_bit | output | 1 | Retimed bit |
| adj_code | input | 5 | Fixed adjust code, signed from center |
| use_train | input | 1 | Use the trained code once training is done |
| train_start | input | 1 | Pulse: start or restart the sweep |
| train_bits | input | 16 | Scored bits per code |
| sel_code | output | 5 | Code currently applied |
| train_done | output | 1 | Sweep finished, kept code available |

## Verification
The bound assertions check the following rules on every cycle:
- the output holds its bit while stalled;
- every accepted word produces a valid bit;
- the applied code changes only on accepted words while a sweep runs;
- a start pulse always restarts at code 0 with train_done cleared;
- train_done stays set.

Other behaviours only the bench scenarios can show. These are the mapping from code to sample index at its wrap points, the exact number of words per code, the error scoring, and the pick of the lowest-error code with ties going to the earliest. The bench shows them by feeding eye shapes whose best code is known in advance.

// File: rtl/phsel_pkg.sv
`timescale 1ns/1ps
package phsel_pkg;
  typedef enum logic {SWEEP_IDLE, SWEEP_RUN} sweep_state_e;

  localparam int unsigned HIST_LEN = 7;

  // Self-synchronizing PRBS7 check: bit should equal hist[5]^hist[6]
  // where hist[0] is the previous bit.
  function automatic logic prbs7_miss(input logic b, input logic [HIST_LEN-1:0] hist);
    return b ^ hist[5] ^ hist[6];
  endfunction
endpackage

// File: rtl/phsel_pick.sv
`timescale 1ns/1ps
module phsel_pick #(
  parameter int unsigned PHASES     = 32,
  parameter int unsigned CENTER_IDX = 16,
  localparam int unsigned CODE_W    = $clog2(PHASES)
) (
  input  logic [PHASES-1:0] samples,
  input  logic [CODE_W-1:0] code,
  output logic              bit_o
);
  logic [CODE_W-1:0] idx;
  logic [PHASES-1:0] onehot;

  // Modulo-PHASES wrap comes from the CODE_W-bit add.
  assign idx = CODE_W'(CENTER_IDX) + code;

  for (genvar p = 0; p < PHASES; p++) begin : g_dec
    assign onehot[p] = (idx == CODE_W'(p));
  end

  assign bit_o = |(onehot & samples);
endmodule

// File: rtl/phsel_outreg.sv
`timescale 1ns/1ps
module phsel_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  output logic s_ready,
  input  logic d_in,
  output logic m_valid,
  input  logic m_ready,
  output logic m_bit
);
  logic take;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_bit   <= 1'b0;
    end else if (take) begin
      m_valid <= 1'b1;
      m_bit   <= d_in;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/phsel_sweep.sv
`timescale 1ns/1ps
module phsel_sweep
  import phsel_pkg::*;
#(
  parameter int unsigned PHASES = 32,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned CODE_W = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              accept,
  input  logic              bit_in,
  input  logic [CNT_W-1:0]  train_bits,
  output logic              busy,
  output logic [CODE_W-1:0] sweep_code,
  output logic [CODE_W-1:0] best_code,
  output logic              done
);
  localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(PHASES - 1);
  localparam logic [2:0]        WARM_FULL = 3'(HIST_LEN);

  sweep_state_e         state;
  logic [2:0]           warm;
  logic [CNT_W-1:0]     bitcnt;
  logic [CNT_W-1:0]     errcnt;
  logic [HIST_LEN-1:0]  hist;
  logic [CNT_W:0]       best_err;

  logic                 miss;
  logic [CNT_W-1:0]     err_total;
  logic [CNT_W-1:0]     eff_bits;
  logic                 last_bit;
  logic                 warmed;

  always_comb begin
    miss      = prbs7_miss(bit_in, hist);
    err_total = errcnt + CNT_W'(miss);
    eff_bits  = (train_bits == '0) ? CNT_W'(1) : train_bits;
    last_bit  = ((CNT_W+1)'(bitcnt) + (CNT_W+1)'(1)) >= (CNT_W+1)'(eff_bits);
    warmed    = (warm == WARM_FULL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SWEEP_IDLE;
      sweep_code <= '0;
      warm       <= '0;
      bitcnt     <= '0;
      errcnt     <= '0;
      hist       <= '0;
      best_err   <= '1;
      best_code  <= '0;
      done       <= 1'b0;
    end else if (start) begin
      state      <= SWEEP_RUN;
      sweep_code <= '0;
      warm       <= '0;
      bitcnt     <= '0;
      errcnt     <= '0;
      hist       <= '0;
      best_err   <= '1;
      best_code  <= '0;
      done       <= 1'b0;
    end else if (state == SWEEP_RUN && accept) begin
      hist <= {hist[HIST_LEN-2:0], bit_in};
      if (!warmed) begin
        warm <= warm + 3'd1;
      end else if (last_bit) begin
        // strict compare keeps the earliest code on ties
        if ((CNT_W+1)'(err_total) < best_err) begin
          best_err  <= (CNT_W+1)'(err_total);
          best_code <= sweep_code;
        end
        errcnt <= '0;
        bitcnt <= '0;
        warm   <= '0;
        if (sweep_code == LAST_CODE) begin
          state <= SWEEP_IDLE;
          done  <= 1'b1;
        end else begin
          sweep_code <= sweep_code + CODE_W'(1);
        end
      end else begin
        errcnt <= err_total;
        bitcnt <= bitcnt + CNT_W'(1);
      end
    end
  end

  assign busy = (state == SWEEP_RUN);
endmodule

// File: rtl/phsel_top.sv
`timescale 1ns/1ps
module phsel_top #(
  parameter int unsigned PHASES     = 32,
  parameter int unsigned CENTER_IDX = 16,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned CODE_W    = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PHASES-1:0] s_samples,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_bit,
  input  logic [CODE_W-1:0] adj_code,
  input  logic              use_train,
  input  logic              train_start,
  input  logic [CNT_W-1:0]  train_bits,
  output logic [CODE_W-1:0] sel_code,
  output logic              train_done
);
  logic              picked;
  logic              accept;
  logic              sweep_busy;
  logic [CODE_W-1:0] sweep_code;
  logic [CODE_W-1:0] best_code;

  assign accept = s_valid && s_ready;

  always_comb begin
    if (sweep_busy)                   sel_code = sweep_code;
    else if (train_done && use_train) sel_code = best_code;
    else                              sel_code = adj_code;
  end

  phsel_pick #(.PHASES(PHASES), .CENTER_IDX(CENTER_IDX)) u_pick (
    .samples (s_samples),
    .code    (sel_code),
    .bit_o   (picked)
  );

  phsel_outreg u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .d_in    (picked),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_bit   (m_bit)
  );

  phsel_sweep #(.PHASES(PHASES), .CNT_W(CNT_W)) u_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (train_start),
    .accept     (accept),
    .bit_in     (picked),
    .train_bits (train_bits),
    .busy       (sweep_busy),
    .sweep_code (sweep_code),
    .best_code  (best_code),
    .done       (train_done)
  );
endmodule

// File: rtl/phsel_chk.sv
`timescale 1ns/1ps
module phsel_chk #(
  parameter int unsigned CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_bit,
  input logic              accept,
  input logic              busy,
  input logic              train_start,
  input logic              train_done,
  input logic [CODE_W-1:0] sel_code
);
  assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_bit)));

  assert_bit_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> m_valid);

  assert_code_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept && !train_start) |=> $stable(sel_code));

  assert_restart_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    train_start |=> (busy && !train_done && sel_code == '0));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (train_done && !train_start) |=> train_done);
endmodule

bind phsel_top phsel_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .m_valid     (m_valid),
  .m_ready     (m_ready),
  .m_bit       (m_bit),
  .accept      (accept),
  .busy        (sweep_busy),
  .train_start (train_start),
  .train_done  (train_done),
  .sel_code    (sel_code)
);

// File: tb/sim_phsel_top.sv
`timescale 1ns/1ps
module sim_phsel_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_samples = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic        m_bit;
  logic [4:0]  adj_code = 5'd3;
  logic        use_train = 1'b0;
  logic        train_start = 1'b0;
  logic [15:0] train_bits = 16'd40;
  logic [4:0]  sel_code;
  logic        train_done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [6:0] lf = 7'h5A;
  int gn = 0;

  always #2 clk = ~clk;

  phsel_top u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_samples(s_samples), .m_valid(m_valid), .m_ready(m_ready), .m_bit(m_bit),
    .adj_code(adj_code), .use_train(use_train), .train_start(train_start),
    .train_bits(train_bits), .sel_code(sel_code), .train_done(train_done)
  );

  // {code, samples, expected bit}; index = (16 + code) mod 32
  localparam logic [37:0] VEC [8] = '{
    {5'b00000, 32'h0001_0000, 1'b1},
    {5'b00000, 32'hFFFE_FFFF, 1'b0},
    {5'b01111, 32'h8000_0000, 1'b1},
    {5'b10000, 32'h0000_0001, 1'b1},
    {5'b11111, 32'h0000_8000, 1'b1},
    {5'b11111, 32'hFFFF_7FFF, 1'b0},
    {5'b00001, 32'h0002_0000, 1'b1},
    {5'b10001, 32'hFFFF_FFFD, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        summary();
      end
    end
  end

  function automatic logic [31:0] make_word(input logic b, input int n, input int scen);
    logic [31:0] w;
    for (int p = 0; p < 32; p++) begin
      logic flip;
      if (scen == 0) flip = !(p >= 10 && p <= 14);
      else if (p == 3) flip = (n % 20 == 0);
      else if (p == 20) flip = (n % 10 == 0);
      else flip = 1'b1;
      w[p] = b ^ flip;
    end
    return w;
  endfunction

  // Feed PRBS7 words; optionally stop once train_done is seen.
  task automatic run_words(input int scen, input int count, input bit stop_on_done, output int used);
    bit broke = 0;
    used = 0;
    for (int k = 0; k < count; k++) begin
      logic b;
      @(negedge clk);
      s_valid = 1'b0;
      if (stop_on_done && train_done) begin broke = 1; break; end
      b = lf[6] ^ lf[5];
      lf = {lf[5:0], b};
      s_samples = make_word(b, gn, scen);
      gn++;
      s_valid = 1'b1;
      used++;
      @(posedge clk);
    end
    if (!broke) begin
      @(negedge clk);
      s_valid = 1'b0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    train_start = 1'b1;
    @(negedge clk);
    train_start = 1'b0;
  endtask

  initial begin
    int used;
    int used2;
    repeat (3) @(negedge clk);
    check("R1 m_valid", m_valid, 0);
    check("R1 train_done", train_done, 0);
    check("R1 s_ready", s_ready, 1);
    check("R1 sel_code", sel_code, 3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 m_valid after reset", m_valid, 0);

    // R2/R3: vector table
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      adj_code  = VEC[i][37:33];
      s_samples = VEC[i][32:1];
      s_valid   = 1'b1;
      @(negedge clk);
      s_valid = 1'b0;
      check($sformatf("R2 R3 vector %0d m_bit", i), m_bit, VEC[i][0]);
      check($sformatf("R3 vector %0d m_valid", i), m_valid, 1);
    end

    // R4: back-pressure
    @(negedge clk);
    adj_code = 5'd0; m_ready = 1'b0; s_samples = 32'hFFFF_FFFF; s_valid = 1'b1;
    @(negedge clk);
    check("R4 m_valid stalled", m_valid, 1);
    check("R4 m_bit stalled", m_bit, 1);
    check("R4 s_ready low", s_ready, 0);
    s_samples = 32'h0;
    @(negedge clk);
    check("R4 m_bit held", m_bit, 1);
    m_ready = 1'b1;
    #1 check("R4 s_ready back", s_ready, 1);
    @(negedge clk);
    s_valid = 1'b0;
    check("R4 next word", m_bit, 0);
    @(negedge clk);
    check("R4 drained", m_valid, 0);

    // R5/R6/R7/R8: scenario A, eye open on phases 10..14
    adj_code = 5'd7;
    train_bits = 16'd40;
    pulse_start();
    check("R5 sweep starts at 0", sel_code, 0);
    check("R9 done cleared", train_done, 0);
    run_words(0, 46, 0, used);
    check("R5 code held for 46 words", sel_code, 0);
    run_words(0, 1, 0, used);
    check("R5 code advances after 47 words", sel_code, 1);
    run_words(0, 3000, 1, used2);
    check("R6 total words for 32 codes", 47 + used2, 1504);
    check("R7 done", train_done, 1);
    use_train = 1'b0;
    #1 check("R8 manual code when use_train=0", sel_code, 7);
    use_train = 1'b1;
    #1 check("R7 best code scenario A (tie to earliest)", sel_code, 26);
    @(negedge clk);
    s_samples = 32'h0000_0400; s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    check("R8 data path uses kept code", m_bit, 1);

    // R7: scenario B, fewest errors at phase 3
    pulse_start();
    run_words(1, 3000, 1, used2);
    check("R7 done scenario B", train_done, 1);
    #1 check("R7 best code scenario B", sel_code, 19);

    // R6: train_bits = 0 behaves as 1
    train_bits = 16'd0;
    pulse_start();
    run_words(0, 3000, 1, used2);
    check("R6 zero train_bits word count", used2, 256);
    #1 check("R6 zero train_bits best code", sel_code, 26);

    // R9: restart mid-sweep
    train_bits = 16'd40;
    pulse_start();
    run_words(0, 50, 0, used);
    check("R9 mid-sweep code", sel_code, 1);
    pulse_start();
    check("R9 restart code", sel_code, 0);
    check("R9 restart done", train_done, 0);

    summary();
  end
endmodule